// File: doc/BRIEF.md
# Timer Group Control and Interrupt Register Bank

This block holds the shared control state for a group of timer channels (eight by default). Four registers live on a small memory-mapped write/read bus: a clock-halt register, a count-enable register, an event flag register and an interrupt mask register. Software never has to read-modify-write them. Each register has a set alias, where every one bit written sets the matching register bit, and a clear alias, where every one bit written clears it. The base address of each register is read-only.

The channels report two kinds of event: a full-count match and a half-count match. Each event pulse latches a bit in the flag register. Full matches use the low half of the word and half matches use the upper half. A single interrupt line is high whenever a flag bit is set and its mask bit is not. The block also drives the per-channel count-enable and clock-halt lines, plus a halt line for a watchdog clock.

Top module: `tmr_ctl_bank`

## Requirements
- R1: After reset, every implemented bit reads as follows. Count-enable (offset 0x00) reads 0. Flags (0x10) read 0. Mask (0x20) reads 0x00FF00FF. Clock-halt (0x0C) reads 0x000100FF. The interrupt output is low.
- R2: A write to a set alias sets each register bit that has a one in the data. The set aliases are 0x04 (enable), 0x14 (flags), 0x24 (mask) and 0x1C (clock-halt). Bits written as zero are unchanged.
- R3: A write to a clear alias clears each register bit that has a one in the data. The clear aliases are 0x08, 0x18, 0x28 and 0x2C, in the same register order as R2. Bits written as zero are unchanged.
- R4: A read of a base offset returns that register's current value. A read of any alias or of an unmapped offset returns zero.
- R5: A one-cycle pulse on full-match input n sets flag bit n. A pulse on half-match input n sets flag bit n+16. The bit stays set until software clears it.
- R6: When a match event and a software clear reach the same flag bit in the same cycle, the bit ends up set.
- R7: The interrupt output is high exactly when some flag bit is one and its mask bit is zero. It follows the register state from the clock edge after the change.
- R8: The count-enable output n is bit n of the enable register. The channel clock-halt output n is bit n of the clock-halt register. The watchdog halt output is bit 16 of the clock-halt register.
- R9: Unimplemented bits always read zero. These are enable bits 8 to 31, flag and mask bits 8 to 15 and 24 to 31, and every clock-halt bit other than 0 to 7 and 16.
- R10: A write to a base offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset for read or write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| full_evt | input | NCH | Full-count match pulses, one per channel |
| half_evt | input | NCH | Half-count match pulses, one per channel |
| run_en | output | NCH | Per-channel count enable |
| clk_halt | output | NCH | Per-channel clock halt |
| wdt_halt | output | 1 | Watchdog clock halt |
| irq | output | 1 | Combined interrupt request |

## Verification
A write or an event that is present at a rising edge changes the register at that edge. The register read-back, the enable and halt outputs and the interrupt line all show the new value in that same cycle, one edge after the stimulus. Bus reads are combinational, so a read issued in a cycle returns the state left by the previous edge. The bench drives all inputs on the falling edge and samples outputs at the next falling edge. For reads it samples 1 ns after placing the address. Every expected value is therefore due exactly one edge after the stimulus that caused it.

// File: rtl/tmr_ctl_pkg.sv
package tmr_ctl_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned HALF_OFS = 16;
  localparam int unsigned WDT_BIT  = 16;

  localparam logic [ADDR_W-1:0] A_EN      = 8'h00;
  localparam logic [ADDR_W-1:0] A_EN_SET  = 8'h04;
  localparam logic [ADDR_W-1:0] A_EN_CLR  = 8'h08;
  localparam logic [ADDR_W-1:0] A_HLT     = 8'h0C;
  localparam logic [ADDR_W-1:0] A_FLG     = 8'h10;
  localparam logic [ADDR_W-1:0] A_FLG_SET = 8'h14;
  localparam logic [ADDR_W-1:0] A_FLG_CLR = 8'h18;
  localparam logic [ADDR_W-1:0] A_HLT_SET = 8'h1C;
  localparam logic [ADDR_W-1:0] A_MSK     = 8'h20;
  localparam logic [ADDR_W-1:0] A_MSK_SET = 8'h24;
  localparam logic [ADDR_W-1:0] A_MSK_CLR = 8'h28;
  localparam logic [ADDR_W-1:0] A_HLT_CLR = 8'h2C;

  typedef logic [REG_W-1:0] word_t;
endpackage

// File: rtl/tmr_sc_reg.sv
module tmr_sc_reg
  import tmr_ctl_pkg::*;
#(
  parameter word_t IMPL = '1,
  parameter word_t RSTV = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set_we,
  input  logic  clr_we,
  input  word_t wdata,
  input  word_t hw_set,
  output word_t q
);
  word_t set_v, clr_v, q_nxt;
  logic  q_en;

  always_comb begin
    set_v = set_we ? wdata : '0;
    clr_v = clr_we ? wdata : '0;
    q_nxt = (((q | set_v) & ~clr_v) | hw_set) & IMPL;
    q_en  = set_we | clr_we | (|hw_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RSTV & IMPL;
    else if (q_en) q <= q_nxt;
  end

  assert_hw_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hw_set & IMPL)) |=> ((q & $past(hw_set & IMPL)) == $past(hw_set & IMPL)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((q & $past(wdata & ~hw_set)) == '0));

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> ((q & $past(wdata & IMPL)) == $past(wdata & IMPL)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we && hw_set == '0) |=> $stable(q));

  assert_impl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~IMPL) == '0);
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
  import tmr_ctl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  word_t             en_q,
  input  word_t             hlt_q,
  input  word_t             flg_q,
  input  word_t             msk_q,
  output word_t             rdata
);
  always_comb begin
    case (addr)
      A_EN:    rdata = en_q;
      A_HLT:   rdata = hlt_q;
      A_FLG:   rdata = flg_q;
      A_MSK:   rdata = msk_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_irq_comb.sv
module tmr_irq_comb
  import tmr_ctl_pkg::*;
(
  input  word_t flg_q,
  input  word_t msk_q,
  output logic  irq
);
  word_t pend;
  always_comb begin
    pend = flg_q & ~msk_q;
    irq  = |pend;
  end
endmodule

// File: rtl/tmr_ctl_bank.sv
module tmr_ctl_bank
  import tmr_ctl_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [NCH-1:0]    full_evt,
  input  logic [NCH-1:0]    half_evt,
  output logic [NCH-1:0]    run_en,
  output logic [NCH-1:0]    clk_halt,
  output logic              wdt_halt,
  output logic              irq
);
  localparam word_t CH_MASK   = word_t'((64'd1 << NCH) - 64'd1);
  localparam word_t EN_IMPL   = CH_MASK;
  localparam word_t EV_IMPL   = CH_MASK | (CH_MASK << HALF_OFS);
  localparam word_t HLT_IMPL  = CH_MASK | (word_t'(1) << WDT_BIT);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_l = rst_sync[1];

  // write decode
  logic en_set, en_clr, hlt_set, hlt_clr, flg_set, flg_clr, msk_set, msk_clr;
  always_comb begin
    en_set  = bus_wr && (bus_addr == A_EN_SET);
    en_clr  = bus_wr && (bus_addr == A_EN_CLR);
    hlt_set = bus_wr && (bus_addr == A_HLT_SET);
    hlt_clr = bus_wr && (bus_addr == A_HLT_CLR);
    flg_set = bus_wr && (bus_addr == A_FLG_SET);
    flg_clr = bus_wr && (bus_addr == A_FLG_CLR);
    msk_set = bus_wr && (bus_addr == A_MSK_SET);
    msk_clr = bus_wr && (bus_addr == A_MSK_CLR);
  end

  word_t flg_hw;
  always_comb begin
    flg_hw = '0;
    flg_hw[NCH-1:0]         = full_evt;
    flg_hw[HALF_OFS +: NCH] = half_evt;
  end

  word_t en_q, hlt_q, flg_q, msk_q;

  tmr_sc_reg #(.IMPL(EN_IMPL), .RSTV('0)) u_en (
    .clk(clk), .rst_n(rst_l), .set_we(en_set), .clr_we(en_clr),
    .wdata(bus_wdata), .hw_set('0), .q(en_q));

  tmr_sc_reg #(.IMPL(HLT_IMPL), .RSTV('1)) u_hlt (
    .clk(clk), .rst_n(rst_l), .set_we(hlt_set), .clr_we(hlt_clr),
    .wdata(bus_wdata), .hw_set('0), .q(hlt_q));

  tmr_sc_reg #(.IMPL(EV_IMPL), .RSTV('0)) u_flg (
    .clk(clk), .rst_n(rst_l), .set_we(flg_set), .clr_we(flg_clr),
    .wdata(bus_wdata), .hw_set(flg_hw), .q(flg_q));

  tmr_sc_reg #(.IMPL(EV_IMPL), .RSTV('1)) u_msk (
    .clk(clk), .rst_n(rst_l), .set_we(msk_set), .clr_we(msk_clr),
    .wdata(bus_wdata), .hw_set('0), .q(msk_q));

  tmr_rd_mux u_rd (
    .addr(bus_addr), .en_q(en_q), .hlt_q(hlt_q), .flg_q(flg_q),
    .msk_q(msk_q), .rdata(bus_rdata));

  tmr_irq_comb u_irq (.flg_q(flg_q), .msk_q(msk_q), .irq(irq));

  assign run_en   = en_q[NCH-1:0];
  assign clk_halt = hlt_q[NCH-1:0];
  assign wdt_halt = hlt_q[WDT_BIT];

  assert_irq_on_event_R7: assert property (@(posedge clk) disable iff (!rst_l)
    ((|(full_evt & ~msk_q[NCH-1:0])) && !msk_set) |=> irq);

  assert_rd_impl_R9: assert property (@(posedge clk) disable iff (!rst_l)
    (bus_rdata & ~(EV_IMPL | HLT_IMPL)) == '0);

  assert_irq_low_R7: assert property (@(posedge clk) disable iff (!rst_l)
    (flg_q == '0) |-> !irq);
endmodule

// File: tb/tmr_ctl_bank_test.sv
module tmr_ctl_bank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  full_evt, half_evt, run_en, clk_halt;
  logic        wdt_halt, irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  tmr_ctl_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .full_evt(full_evt),
    .half_evt(half_evt), .run_en(run_en), .clk_halt(clk_halt),
    .wdt_halt(wdt_halt), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    chk("R1 run_en", 32'(run_en), 32'h0);
    chk("R1 clk_halt", 32'(clk_halt), 32'hFF);
    chk("R1 wdt_halt", 32'(wdt_halt), 32'h1);
    chk("R1 irq", 32'(irq), 32'h0);
    rdchk("R1 enable", 8'h00, 32'h0);
    rdchk("R1 halt", 8'h0C, 32'h000100FF);
    rdchk("R1 flags", 8'h10, 32'h0);
    rdchk("R1 mask", 8'h20, 32'h00FF00FF);
  endtask

  task automatic t_set_clear;
    wr(8'h04, 32'h11); rdchk("R2 set", 8'h00, 32'h11);
    wr(8'h04, 32'h02); rdchk("R2 zeros kept", 8'h00, 32'h13);
    wr(8'h08, 32'h01); rdchk("R3 clear", 8'h00, 32'h12);
    chk("R8 run_en", 32'(run_en), 32'h12);
    wr(8'h2C, 32'h00010003); rdchk("R3 halt clear", 8'h0C, 32'h000000FC);
    chk("R8 clk_halt", 32'(clk_halt), 32'hFC);
    chk("R8 wdt run", 32'(wdt_halt), 32'h0);
    wr(8'h1C, 32'h00010000); rdchk("R2 halt set", 8'h0C, 32'h000100FC);
    chk("R8 wdt halt", 32'(wdt_halt), 32'h1);
  endtask

  task automatic t_alias;
    rdchk("R4 en set alias", 8'h04, 0); rdchk("R4 en clr alias", 8'h08, 0);
    rdchk("R4 flg set alias", 8'h14, 0); rdchk("R4 flg clr alias", 8'h18, 0);
    rdchk("R4 msk set alias", 8'h24, 0); rdchk("R4 msk clr alias", 8'h28, 0);
    rdchk("R4 hlt set alias", 8'h1C, 0); rdchk("R4 hlt clr alias", 8'h2C, 0);
    rdchk("R4 unmapped", 8'h30, 0);
  endtask

  task automatic t_base_write;
    wr(8'h00, 32'hFF); rdchk("R10 enable base", 8'h00, 32'h12);
    wr(8'h20, 32'h0);  rdchk("R10 mask base", 8'h20, 32'h00FF00FF);
    wr(8'h10, 32'hFF); rdchk("R10 flag base", 8'h10, 32'h0);
  endtask

  task automatic t_unimpl;
    wr(8'h04, 32'hFFFFFFFF); rdchk("R9 enable", 8'h00, 32'hFF);
    wr(8'h08, 32'hFFFFFFFF); rdchk("R3 enable all", 8'h00, 32'h0);
    wr(8'h14, 32'hFFFFFFFF); rdchk("R9 flags", 8'h10, 32'h00FF00FF);
    wr(8'h18, 32'hFFFFFFFF); rdchk("R3 flags all", 8'h10, 32'h0);
    wr(8'h1C, 32'hFFFFFFFF); rdchk("R9 halt", 8'h0C, 32'h000100FF);
  endtask

  task automatic t_events;
    @(negedge clk); full_evt = 8'h80;
    @(negedge clk); full_evt = 8'h00;
    rdchk("R5 full ch7", 8'h10, 32'h00000080);
    @(negedge clk); half_evt = 8'h01;
    @(negedge clk); half_evt = 8'h00;
    rdchk("R5 half ch0", 8'h10, 32'h00010080);
    repeat (3) @(negedge clk);
    rdchk("R5 sticky", 8'h10, 32'h00010080);
    wr(8'h18, 32'h00010080); rdchk("R3 flag clear", 8'h10, 32'h0);
  endtask

  task automatic t_race;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h00000005; full_evt = 8'h04;
    @(negedge clk);
    bus_wr = 1'b0; full_evt = 8'h00;
    rdchk("R6 event beats clear", 8'h10, 32'h00000004);
    wr(8'h18, 32'h4); rdchk("R6 cleared after", 8'h10, 32'h0);
  endtask

  task automatic t_irq;
    @(negedge clk); full_evt = 8'h04;
    @(negedge clk); full_evt = 8'h00;
    chk("R7 masked", 32'(irq), 0);
    wr(8'h28, 32'h4); chk("R7 unmasked", 32'(irq), 1);
    wr(8'h24, 32'h4); chk("R7 remasked", 32'(irq), 0);
    wr(8'h18, 32'h4);
    wr(8'h28, 32'h00200000); chk("R7 no flag", 32'(irq), 0);
    @(negedge clk); half_evt = 8'h20;
    @(negedge clk); half_evt = 8'h00;
    chk("R7 half ch5", 32'(irq), 1);
    wr(8'h18, 32'h00200000); chk("R7 flag cleared", 32'(irq), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    full_evt = '0; half_evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_set_clear;
    t_alias;
    t_base_write;
    t_unimpl;
    t_events;
    t_race;
    t_irq;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule